// File: doc/BRIEF.md
# Three-format 32-bit single-cycle processor core

This block is a small 32-bit processor that finishes one instruction per clock cycle. On each cycle it reads the instruction word at the program counter and decodes it as one of three fixed 32-bit formats: register, immediate or jump. It reads up to two source registers and computes a result, an address or a branch decision. On the rising clock edge it writes the register file or the data memory and moves the program counter. The core handles twelve operations: ADD, SUB, AND, OR, SLL, SRL, ADDI, LW, SW, BEQ, BNE and J. Any other encoding runs as a no-op.

The instruction memory and the data memory are arrays inside the top module. Both are written on the clock edge and read without a clock. The instruction memory is filled through a load port while reset is held. After reset is released, the core runs on its own. The program counter, the register write-back event and the data-memory store event are brought out as ports, so a harness can follow execution cycle by cycle.

Top module: `sc_core_top`

## Requirements
- R1: While the synchronous active-high `rst` is sampled high on a rising edge, the program counter becomes 0 and no register or data-memory write takes place (`wb_en` and `dm_we` are low while `rst` is high).
- R2: Every instruction is 32 bits. For any instruction that is not a taken branch or a jump, the next program counter is PC+4.
- R3: Register format is opcode bits [31:26] = 000000. Funct bits [5:0] select the operation: 100000 ADD, 100010 SUB, 100100 AND, 100101 OR. The operation is applied to rs (bits [25:21]) and rt (bits [20:16]), and the result is written to rd (bits [15:11]).
- R4: SLL (funct 000000) and SRL (funct 000010) shift rt by the shamt field (bits [10:6]) and write rd. SRL fills with zeros.
- R5: ADDI (opcode 001000) writes rt with rs plus the immediate in bits [15:0], sign-extended to 32 bits.
- R6: LW (opcode 100011) and SW (opcode 101011) use the byte address rs plus the sign-extended immediate. The data-memory word index is address bits [log2(DMEM_WORDS)+1:2]. LW writes the word read to rt. SW stores rt.
- R7: BEQ (opcode 000100) is taken when rs equals rt. BNE (opcode 000101) is taken when rs differs from rt. A taken branch sets PC to PC+4 plus the sign-extended immediate shifted left by 2. An untaken branch sets PC to PC+4.
- R8: J (opcode 000010) sets PC to {PC+4[31:28], bits [25:0], 2'b00}.
- R9: Register 0 always reads as zero. A write aimed at register 0 does not happen and raises no `wb_en`.
- R10: Any other opcode, and any other funct under opcode 000000, writes no register and no memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Write strobe for the instruction-memory load port |
| ld_addr | input | log2(IMEM_WORDS) | Word index written by the load port |
| ld_data | input | 32 | Instruction word written by the load port |
| pc_o | output | 32 | Current program counter (registered) |
| wb_en | output | 1 | A register write happens at the next rising edge |
| wb_addr | output | 5 | Destination register of that write |
| wb_data | output | 32 | Value being written |
| dm_we | output | 1 | A data-memory store happens at the next rising edge |
| dm_addr | output | 32 | Byte address of the load or store |
| dm_wdata | output | 32 | Store data |

## Verification
The bench builds the core with IMEM_WORDS = 64 and DMEM_WORDS = 32. The 64-word instruction memory holds a 30-instruction program. That program includes a backward BNE loop, forward taken and untaken branches, a jump over dead code, a self-jump halt and two undefined encodings. The 32-word data memory lets a negative-offset store and load reach word 14, and a positive offset reach word 17, from the same base register. A second reset in the middle of the run restarts the program while register and memory contents are kept, so every instruction runs again on changed state.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned XLEN = 32;

  localparam logic [5:0] OP_RFMT = 6'b000000;
  localparam logic [5:0] OP_ADDI = 6'b001000;
  localparam logic [5:0] OP_LW   = 6'b100011;
  localparam logic [5:0] OP_SW   = 6'b101011;
  localparam logic [5:0] OP_BEQ  = 6'b000100;
  localparam logic [5:0] OP_BNE  = 6'b000101;
  localparam logic [5:0] OP_J    = 6'b000010;

  localparam logic [5:0] FN_SLL = 6'b000000;
  localparam logic [5:0] FN_SRL = 6'b000010;
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLL, ALU_SRL
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    src_imm;
    logic    mem_rd;
    logic    mem_we;
    logic    br_eq;
    logic    br_ne;
    logic    jump;
    logic    known;
    alu_op_e alu_op;
  } ctl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl
);
  always_comb begin
    ctl = '0;
    ctl.known = 1'b1;
    case (opcode)
      OP_RFMT: begin
        ctl.reg_we = 1'b1;
        ctl.dst_rd = 1'b1;
        case (funct)
          FN_ADD: ctl.alu_op = ALU_ADD;
          FN_SUB: ctl.alu_op = ALU_SUB;
          FN_AND: ctl.alu_op = ALU_AND;
          FN_OR:  ctl.alu_op = ALU_OR;
          FN_SLL: ctl.alu_op = ALU_SLL;
          FN_SRL: ctl.alu_op = ALU_SRL;
          default: begin
            ctl.reg_we = 1'b0;
            ctl.known  = 1'b0;
          end
        endcase
      end
      OP_ADDI: begin
        ctl.reg_we  = 1'b1;
        ctl.src_imm = 1'b1;
      end
      OP_LW: begin
        ctl.reg_we  = 1'b1;
        ctl.src_imm = 1'b1;
        ctl.mem_rd  = 1'b1;
      end
      OP_SW: begin
        ctl.src_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OP_BEQ:  ctl.br_eq = 1'b1;
      OP_BNE:  ctl.br_ne = 1'b1;
      OP_J:    ctl.jump  = 1'b1;
      default: ctl.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG  = 32,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic [AW-1:0]    ra1,
  input  logic [AW-1:0]    ra2,
  output logic [WIDTH-1:0] rd1,
  output logic [WIDTH-1:0] rd2
);
  logic [WIDTH-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SW   = $clog2(WIDTH)
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [SW-1:0]    shamt,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLL: y = b << shamt;
      ALU_SRL: y = b >> shamt;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/sc_core_top.sv
module sc_core_top
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_we,
  input  logic [IAW-1:0]  ld_addr,
  input  logic [31:0]     ld_data,
  output logic [31:0]     pc_o,
  output logic            wb_en,
  output logic [4:0]      wb_addr,
  output logic [31:0]     wb_data,
  output logic            dm_we,
  output logic [31:0]     dm_addr,
  output logic [31:0]     dm_wdata
);
  logic [XLEN-1:0] pc_q, pc_plus4, pc_next, br_tgt, j_tgt;
  logic [XLEN-1:0] instr, imm_sx, rs_val, rt_val, alu_b, alu_y, ld_val;
  logic [4:0]      dst;
  logic            take_br;
  ctl_t            ctl;

  // Instruction store: synchronous load, asynchronous fetch
  logic [XLEN-1:0] imem [IMEM_WORDS];
  always_ff @(posedge clk) begin
    if (ld_we) imem[ld_addr] <= ld_data;
  end
  assign instr = imem[pc_q[IAW+1:2]];

  sc_decode u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctl    (ctl)
  );

  assign imm_sx = {{16{instr[15]}}, instr[15:0]};
  assign dst    = ctl.dst_rd ? instr[15:11] : instr[20:16];
  assign wb_en  = ctl.reg_we && !rst && (dst != 5'd0);

  sc_regfile #(.NREG(32), .WIDTH(XLEN)) u_rf (
    .clk (clk),
    .we  (wb_en),
    .wa  (dst),
    .wd  (wb_data),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .rd1 (rs_val),
    .rd2 (rt_val)
  );

  assign alu_b = ctl.src_imm ? imm_sx : rt_val;

  sc_alu #(.WIDTH(XLEN)) u_alu (
    .op    (ctl.alu_op),
    .a     (rs_val),
    .b     (alu_b),
    .shamt (instr[10:6]),
    .y     (alu_y)
  );

  // Data store: synchronous write, asynchronous read
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  always_ff @(posedge clk) begin
    if (dm_we) dmem[alu_y[DAW+1:2]] <= rt_val;
  end
  assign ld_val = dmem[alu_y[DAW+1:2]];

  assign wb_data  = ctl.mem_rd ? ld_val : alu_y;
  assign wb_addr  = dst;
  assign dm_we    = ctl.mem_we && !rst;
  assign dm_addr  = alu_y;
  assign dm_wdata = rt_val;

  // Next-PC selection
  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = pc_plus4 + {imm_sx[29:0], 2'b00};
  assign j_tgt    = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign take_br  = (ctl.br_eq && (rs_val == rt_val)) ||
                    (ctl.br_ne && (rs_val != rt_val));

  always_comb begin
    if (ctl.jump)      pc_next = j_tgt;
    else if (take_br)  pc_next = br_tgt;
    else               pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_o = pc_q;

  assert_reset_pc_R1: assert property (@(posedge clk)
    rst |=> (pc_q == '0));

  assert_seq_pc_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctl.jump && !ctl.br_eq && !ctl.br_ne) |=> (pc_q == $past(pc_q) + 32'd4));

  assert_beq_taken_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl.br_eq && (rs_val == rt_val)) |=>
      (pc_q == $past(pc_q) + 32'd4 + {$past(imm_sx[29:0]), 2'b00}));

  assert_jump_target_R8: assert property (@(posedge clk) disable iff (rst)
    ctl.jump |=> (pc_q == {$past(pc_q[31:28]), $past(instr[25:0]), 2'b00}));

  assert_unknown_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !ctl.known |-> (!wb_en && !dm_we));
endmodule

// File: tb/tb_sc_core_top.sv
`timescale 1ns/1ps
module tb_sc_core_top;
  localparam int IMW = 64;
  localparam int DMW = 32;
  localparam int IAW = $clog2(IMW);
  localparam int DAW = $clog2(DMW);

  logic           clk = 1'b0;
  logic           rst;
  logic           ld_we;
  logic [IAW-1:0] ld_addr;
  logic [31:0]    ld_data;
  logic [31:0]    pc_o, wb_data, dm_addr, dm_wdata;
  logic [4:0]     wb_addr;
  logic           wb_en, dm_we;

  always #4 clk = ~clk;

  sc_core_top #(.IMEM_WORDS(IMW), .DMEM_WORDS(DMW)) dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .pc_o(pc_o), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
  );

  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 0;
  logic [31:0] prog [IMW];
  logic [31:0] mreg [32];
  logic [31:0] mmem [DMW];
  logic [31:0] m_pc;
  string       pc_tag;

  function automatic logic [31:0] rfmt(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction
  function automatic logic [31:0] ifmt(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] jfmt(int target_word);
    return {6'b000010, 26'(target_word)};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h (pc model %h)", tag, what, act, exp, m_pc);
    end
  endtask

  // Behavioural reference: one instruction per call, compared then applied
  task automatic model_cycle();
    logic [31:0] w, a, b, sx, nxt, e_wbd, e_da, e_dd;
    logic [4:0]  e_wba;
    logic        e_wb, e_dw;
    string       tg, pct;
    w  = prog[m_pc[IAW+1:2]];
    a  = mreg[w[25:21]];
    b  = mreg[w[20:16]];
    sx = {{16{w[15]}}, w[15:0]};
    nxt = m_pc + 4;
    e_wb = 0; e_dw = 0; e_wba = 0; e_wbd = 0; e_da = 0; e_dd = 0;
    tg = "R10"; pct = "R2";
    case (w[31:26])
      6'b000000: begin
        e_wba = w[15:11];
        case (w[5:0])
          6'b100000: begin e_wb = 1; e_wbd = a + b; tg = "R3"; end
          6'b100010: begin e_wb = 1; e_wbd = a - b; tg = "R3"; end
          6'b100100: begin e_wb = 1; e_wbd = a & b; tg = "R3"; end
          6'b100101: begin e_wb = 1; e_wbd = a | b; tg = "R3"; end
          6'b000000: begin e_wb = 1; e_wbd = b << w[10:6]; tg = "R4"; end
          6'b000010: begin e_wb = 1; e_wbd = b >> w[10:6]; tg = "R4"; end
          default: ;
        endcase
      end
      6'b001000: begin e_wb = 1; e_wba = w[20:16]; e_wbd = a + sx; tg = "R5"; end
      6'b100011: begin
        e_wb = 1; e_wba = w[20:16]; e_da = a + sx;
        e_wbd = mmem[e_da[DAW+1:2]]; tg = "R6";
      end
      6'b101011: begin e_dw = 1; e_da = a + sx; e_dd = b; tg = "R6"; end
      6'b000100: begin tg = "R7"; pct = "R7"; if (a == b) nxt = m_pc + 4 + (sx << 2); end
      6'b000101: begin tg = "R7"; pct = "R7"; if (a != b) nxt = m_pc + 4 + (sx << 2); end
      6'b000010: begin
        tg = "R8"; pct = "R8";
        nxt = {m_pc[31:28] + 4'(m_pc[27:0] > 28'hFFFFFFB), w[25:0], 2'b00};
      end
      default: ;
    endcase
    if (e_wb && e_wba == 5'd0) begin e_wb = 0; tg = "R9"; end

    chk(pc_tag, "pc", pc_o, m_pc);
    chk(tg, "wb_en", {31'b0, wb_en}, {31'b0, e_wb});
    if (e_wb) begin
      chk(tg, "wb_addr", {27'b0, wb_addr}, {27'b0, e_wba});
      chk(tg, "wb_data", wb_data, e_wbd);
    end
    chk(tg, "dm_we", {31'b0, dm_we}, {31'b0, e_dw});
    if (e_dw) begin
      chk(tg, "dm_addr", dm_addr, e_da);
      chk(tg, "dm_wdata", dm_wdata, e_dd);
    end

    if (e_wb) mreg[e_wba] = e_wbd;
    if (e_dw) mmem[e_da[DAW+1:2]] = e_dd;
    pc_tag = pct;
    m_pc   = nxt;
  endtask

  task automatic run(int cycles);
    rst = 1'b0;
    #1;
    m_pc = 32'd0;
    pc_tag = "R1";
    for (int c = 0; c < cycles; c++) begin
      model_cycle();
      @(negedge clk);
    end
  endtask

  initial begin
    rst = 1'b1; ld_we = 1'b0; ld_addr = '0; ld_data = '0;
    for (int i = 0; i < 32; i++)  mreg[i] = 32'd0;
    for (int i = 0; i < DMW; i++) mmem[i] = 32'd0;
    for (int i = 0; i < IMW; i++) prog[i] = 32'd0;

    prog[0]  = ifmt(6'b001000, 0, 1, 3);              // addi r1 = 3
    prog[1]  = ifmt(6'b001000, 0, 2, -5);             // addi r2 = -5
    prog[2]  = rfmt(2, 1, 2, 0, 6'b100000);           // loop: add r2 += r1
    prog[3]  = ifmt(6'b001000, 1, 1, -1);             // r1 -= 1
    prog[4]  = ifmt(6'b000101, 1, 0, -3);             // bne r1, r0 -> loop
    prog[5]  = ifmt(6'b001000, 0, 3, 16'h7F0F);
    prog[6]  = ifmt(6'b001000, 0, 4, 16'h00FF);
    prog[7]  = rfmt(3, 4, 5, 0, 6'b100100);           // and
    prog[8]  = rfmt(3, 4, 6, 0, 6'b100101);           // or
    prog[9]  = rfmt(2, 3, 7, 0, 6'b100010);           // sub, negative
    prog[10] = rfmt(0, 3, 8, 4, 6'b000000);           // sll 4
    prog[11] = rfmt(0, 7, 9, 3, 6'b000010);           // srl 3, zero fill
    prog[12] = ifmt(6'b001000, 0, 10, 64);
    prog[13] = ifmt(6'b101011, 10, 7, -8);            // sw word 14
    prog[14] = ifmt(6'b101011, 10, 6, 4);             // sw word 17
    prog[15] = ifmt(6'b100011, 10, 11, -8);           // lw
    prog[16] = ifmt(6'b001000, 3, 0, 5);              // write to r0
    prog[17] = rfmt(0, 3, 12, 0, 6'b100000);          // read r0
    prog[18] = ifmt(6'b000100, 11, 7, 1);             // beq taken
    prog[19] = ifmt(6'b001000, 0, 13, 1);             // skipped
    prog[20] = ifmt(6'b000100, 11, 6, 5);             // beq not taken
    prog[21] = {6'b111111, 26'h0123456};              // unknown opcode
    prog[22] = rfmt(1, 2, 5, 0, 6'b111111);           // unknown funct
    prog[23] = jfmt(26);
    prog[24] = ifmt(6'b001000, 0, 14, 9);             // skipped
    prog[25] = ifmt(6'b001000, 0, 15, 9);             // skipped
    prog[26] = ifmt(6'b100011, 10, 13, 4);            // lw word 17
    prog[27] = ifmt(6'b000101, 13, 6, 2);             // bne not taken
    prog[28] = 32'd0;                                 // sll r0: no write
    prog[29] = jfmt(29);                              // halt

    for (int i = 0; i < IMW; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = IAW'(i); ld_data = prog[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
    @(negedge clk);
    chk("R1", "pc in reset", pc_o, 32'd0);
    chk("R1", "wb_en in reset", {31'b0, wb_en}, 32'd0);
    chk("R1", "dm_we in reset", {31'b0, dm_we}, 32'd0);

    run(60);

    rst = 1'b1;
    @(negedge clk);
    chk("R1", "pc after mid-run reset", pc_o, 32'd0);
    chk("R1", "wb_en in reset", {31'b0, wb_en}, 32'd0);
    run(50);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule